// File: doc/BRIEF.md
# Register Write-Protection Unlock Controller

This block sits on a simple peripheral register bus (address, write strobe, write data, read strobe, read data) and guards a small group of critical control registers against accidental writes. Out of reset the guard is closed. Software opens it by writing a fixed three-word key to a dedicated lock register, one word per bus cycle, with no other bus write in between. Once open, the guarded registers accept writes. Any later write to the lock register closes the guard again.

The bank holds two guarded registers: one with a clock source select and a watchdog clock enable, and one with a brown-out threshold select, a brown-out enable and a low-voltage reset enable. It also holds a status register with a sticky violation flag and a scratch register that is never guarded. A write to a guarded register while the guard is closed is dropped and sets the violation flag, which software clears by writing 1 to it. All reads go through one registered read port.

Top module: `wp_unlock_ctrl`

## Requirements
- R1: After synchronous reset the guard is closed (`prot_unlocked`=0), the lock register (address 0x0) reads 0, the violation flag is 0, the clock-control register (address 0x2) reads 0x0000 and the power-control register (address 0x3) reads 0x0080.
- R2: Writing 0x0059, then 0x0016, then 0x0088 (the full 16-bit word must match) to address 0x0 in three consecutive bus writes opens the guard; `prot_unlocked` and lock-register bit 0 read 1 from the cycle after the third write.
- R3: A write to address 0x0 with a value that does not match the expected key word restarts the sequence; if that value is 0x0059 it counts as the first key word of a new attempt.
- R4: A bus write to any address other than 0x0 between key words restarts the sequence from the beginning.
- R5: Bus reads from any address, including 0x0, neither advance nor restart the key sequence, and leave the open guard open.
- R6: While the guard is open, a write of any value to address 0x0 closes it from the next cycle, and that write does not count as a key word.
- R7: While closed, writes to address 0x2 (bits [1:0] clock source select, bit 4 watchdog clock enable) and address 0x3 (bit 0 brown-out enable, bits [3:1] threshold select, bit 7 low-voltage reset enable) leave every field at its previous value; while open, they update the fields from the next cycle.
- R8: The scratch register (address 0x4, full width) accepts writes whether the guard is open or closed.
- R9: A write to address 0x2 or 0x3 while closed sets the violation flag (`viol_flag`, status register address 0x1 bit 0) from the next cycle; it stays set until a write to address 0x1 with bit 0 = 1, and a write there with bit 0 = 0 leaves it unchanged.
- R10: Read data is registered: `bus_rdata` shows the addressed register one cycle after `bus_rd`, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (16) | Registered read data |
| prot_unlocked | output | 1 | 1 while guarded registers are writable |
| viol_flag | output | 1 | Sticky blocked-write flag |
| clk_src_sel | output | 2 | Guarded clock source select |
| wdt_clk_en | output | 1 | Guarded watchdog clock enable |
| bod_thresh | output | 3 | Guarded brown-out threshold select |
| bod_en | output | 1 | Guarded brown-out enable |
| lvr_en | output | 1 | Guarded low-voltage reset enable |

## Verification
On every cycle the assertions check that the guard opens only on the cycle after a final key word, closes after any lock-register write while open, stays open otherwise, that guarded fields hold across a closed-guard write, and that the violation flag sets and holds as required. Whether a given order of words, with wrong values, repeated first words, interleaved foreign writes or reads, actually reaches the open state can only be shown by the bench's directed sequences, as can the read port's values and the scratch register's behaviour.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_GOT1 = 2'd1,
    KS_GOT2 = 2'd2
  } key_state_t;

  localparam int CLKSEL_W = 2;
  localparam int THRESH_W = 3;

  // field positions inside the guarded registers
  localparam int CLK_SEL_LSB = 0;
  localparam int CLK_WDT_BIT = 4;
  localparam int PWR_BOD_BIT = 0;
  localparam int PWR_THR_LSB = 1;
  localparam int PWR_LVR_BIT = 7;

endpackage

// File: rtl/wp_key_tracker.sv
module wp_key_tracker
  import wp_pkg::*;
#(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 16,
  parameter logic [ADDR_W-1:0]  LOCK_ADDR = '0,
  parameter logic [DATA_W-1:0]  KEY_A     = 16'h0059,
  parameter logic [DATA_W-1:0]  KEY_B     = 16'h0016,
  parameter logic [DATA_W-1:0]  KEY_C     = 16'h0088
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked
);

  key_state_t st_q, st_d;
  logic       unl_d;
  logic       lock_hit;
  logic       is_a, is_b, is_c;
  key_state_t restart;

  assign lock_hit = wr_en && (wr_addr == LOCK_ADDR);
  assign is_a     = (wr_data == KEY_A);
  assign is_b     = (wr_data == KEY_B);
  assign is_c     = (wr_data == KEY_C);
  // a mismatching word that equals the first key starts a fresh attempt
  assign restart  = is_a ? KS_GOT1 : KS_IDLE;

  always_comb begin
    st_d  = st_q;
    unl_d = unlocked;
    if (unlocked) begin
      st_d = KS_IDLE;
      if (lock_hit) unl_d = 1'b0;
    end else if (wr_en) begin
      if (!lock_hit) begin
        st_d = KS_IDLE;
      end else begin
        unique case (st_q)
          KS_IDLE: st_d = restart;
          KS_GOT1: st_d = is_b ? KS_GOT2 : restart;
          KS_GOT2: begin
            if (is_c) begin
              st_d  = KS_IDLE;
              unl_d = 1'b1;
            end else begin
              st_d = restart;
            end
          end
          default: st_d = KS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= KS_IDLE;
      unlocked <= 1'b0;
    end else begin
      st_q     <= st_d;
      unlocked <= unl_d;
    end
  end

endmodule

// File: rtl/wp_prot_bank.sv
module wp_prot_bank
  import wp_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1,
  parameter logic [ADDR_W-1:0] PCLK_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] PPWR_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] SCR_ADDR  = 4'h4,
  parameter int                NUM_PROT  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                unlocked,
  output logic [CLKSEL_W-1:0] clk_sel,
  output logic                wdt_en,
  output logic [THRESH_W-1:0] thresh,
  output logic                bod_en,
  output logic                lvr_en,
  output logic [DATA_W-1:0]   scratch,
  output logic                viol
);

  localparam logic [ADDR_W-1:0] PROT_ADDRS [NUM_PROT] = '{PCLK_ADDR, PPWR_ADDR};

  logic [NUM_PROT-1:0] prot_hit;
  logic [NUM_PROT-1:0] prot_we;
  logic                any_prot_hit;
  logic                blocked;
  logic                stat_clr;

  // one address match and one gated write enable per guarded register
  for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
    assign prot_hit[g] = wr_en && (wr_addr == PROT_ADDRS[g]);
    assign prot_we[g]  = prot_hit[g] && unlocked;
  end

  assign any_prot_hit = |prot_hit;
  assign blocked      = any_prot_hit && !unlocked;
  assign stat_clr     = wr_en && (wr_addr == STAT_ADDR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sel <= '0;
      wdt_en  <= 1'b0;
    end else if (prot_we[0]) begin
      clk_sel <= wr_data[CLK_SEL_LSB +: CLKSEL_W];
      wdt_en  <= wr_data[CLK_WDT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bod_en <= 1'b0;
      thresh <= '0;
      lvr_en <= 1'b1;
    end else if (prot_we[1]) begin
      bod_en <= wr_data[PWR_BOD_BIT];
      thresh <= wr_data[PWR_THR_LSB +: THRESH_W];
      lvr_en <= wr_data[PWR_LVR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch <= '0;
    end else if (wr_en && (wr_addr == SCR_ADDR)) begin
      scratch <= wr_data;
    end
  end

  // set has priority; the two cannot coincide on a single-address bus
  always_ff @(posedge clk) begin
    if (rst) begin
      viol <= 1'b0;
    end else if (blocked) begin
      viol <= 1'b1;
    end else if (stat_clr) begin
      viol <= 1'b0;
    end
  end

endmodule

// File: rtl/wp_read_mux.sv
module wp_read_mux
  import wp_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1,
  parameter logic [ADDR_W-1:0] PCLK_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] PPWR_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] SCR_ADDR  = 4'h4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                unlocked,
  input  logic                viol,
  input  logic [CLKSEL_W-1:0] clk_sel,
  input  logic                wdt_en,
  input  logic [THRESH_W-1:0] thresh,
  input  logic                bod_en,
  input  logic                lvr_en,
  input  logic [DATA_W-1:0]   scratch,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] clk_word, pwr_word, rd_d;

  always_comb begin
    clk_word = '0;
    clk_word[CLK_SEL_LSB +: CLKSEL_W] = clk_sel;
    clk_word[CLK_WDT_BIT]             = wdt_en;
    pwr_word = '0;
    pwr_word[PWR_BOD_BIT]             = bod_en;
    pwr_word[PWR_THR_LSB +: THRESH_W] = thresh;
    pwr_word[PWR_LVR_BIT]             = lvr_en;
  end

  always_comb begin
    rd_d = '0;
    if (rd_addr == LOCK_ADDR)      rd_d[0] = unlocked;
    else if (rd_addr == STAT_ADDR) rd_d[0] = viol;
    else if (rd_addr == PCLK_ADDR) rd_d    = clk_word;
    else if (rd_addr == PPWR_ADDR) rd_d    = pwr_word;
    else if (rd_addr == SCR_ADDR)  rd_d    = scratch;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

endmodule

// File: rtl/wp_unlock_ctrl.sv
module wp_unlock_ctrl
  import wp_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1,
  parameter logic [ADDR_W-1:0] PCLK_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] PPWR_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] SCR_ADDR  = 4'h4,
  parameter logic [DATA_W-1:0] KEY_A     = 16'h0059,
  parameter logic [DATA_W-1:0] KEY_B     = 16'h0016,
  parameter logic [DATA_W-1:0] KEY_C     = 16'h0088
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                prot_unlocked,
  output logic                viol_flag,
  output logic [CLKSEL_W-1:0] clk_src_sel,
  output logic                wdt_clk_en,
  output logic [THRESH_W-1:0] bod_thresh,
  output logic                bod_en,
  output logic                lvr_en
);

  logic [DATA_W-1:0] scratch;

  wp_key_tracker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C)
  ) u_trk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .unlocked (prot_unlocked)
  );

  wp_prot_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR),
    .PCLK_ADDR(PCLK_ADDR), .PPWR_ADDR(PPWR_ADDR), .SCR_ADDR(SCR_ADDR),
    .NUM_PROT(2)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .unlocked (prot_unlocked),
    .clk_sel  (clk_src_sel),
    .wdt_en   (wdt_clk_en),
    .thresh   (bod_thresh),
    .bod_en   (bod_en),
    .lvr_en   (lvr_en),
    .scratch  (scratch),
    .viol     (viol_flag)
  );

  wp_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
    .STAT_ADDR(STAT_ADDR), .PCLK_ADDR(PCLK_ADDR), .PPWR_ADDR(PPWR_ADDR),
    .SCR_ADDR(SCR_ADDR)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd),
    .rd_addr  (bus_addr),
    .unlocked (prot_unlocked),
    .viol     (viol_flag),
    .clk_sel  (clk_src_sel),
    .wdt_en   (wdt_clk_en),
    .thresh   (bod_thresh),
    .bod_en   (bod_en),
    .lvr_en   (lvr_en),
    .scratch  (scratch),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/wp_unlock_chk.sv
module wp_unlock_chk
  import wp_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1,
  parameter logic [ADDR_W-1:0] PCLK_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] PPWR_ADDR = 4'h3,
  parameter logic [DATA_W-1:0] KEY_C     = 16'h0088
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                prot_unlocked,
  input logic                viol_flag,
  input logic [CLKSEL_W-1:0] clk_src_sel,
  input logic                wdt_clk_en,
  input logic [THRESH_W-1:0] bod_thresh,
  input logic                bod_en,
  input logic                lvr_en
);

  logic lock_wr, pclk_wr, ppwr_wr, clr_wr;
  assign lock_wr = bus_wr && (bus_addr == LOCK_ADDR);
  assign pclk_wr = bus_wr && (bus_addr == PCLK_ADDR);
  assign ppwr_wr = bus_wr && (bus_addr == PPWR_ADDR);
  assign clr_wr  = bus_wr && (bus_addr == STAT_ADDR) && bus_wdata[0];

  p_reset_closed_r1: assert property (@(posedge clk)
    rst |=> (!prot_unlocked && !viol_flag));

  p_open_after_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_unlocked) |-> $past(lock_wr && (bus_wdata == KEY_C)));

  p_open_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (prot_unlocked && !lock_wr) |=> prot_unlocked);

  p_relock_r6: assert property (@(posedge clk) disable iff (rst)
    (prot_unlocked && lock_wr) |=> !prot_unlocked);

  p_hold_clk_r7: assert property (@(posedge clk) disable iff (rst)
    (!prot_unlocked && pclk_wr) |=> ($stable(clk_src_sel) && $stable(wdt_clk_en)));

  p_hold_pwr_r7: assert property (@(posedge clk) disable iff (rst)
    (!prot_unlocked && ppwr_wr) |=> ($stable(bod_thresh) && $stable(bod_en) && $stable(lvr_en)));

  p_viol_set_r9: assert property (@(posedge clk) disable iff (rst)
    (!prot_unlocked && (pclk_wr || ppwr_wr)) |=> viol_flag);

  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !clr_wr) |=> viol_flag);

endmodule

bind wp_unlock_ctrl wp_unlock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
  .STAT_ADDR(STAT_ADDR), .PCLK_ADDR(PCLK_ADDR), .PPWR_ADDR(PPWR_ADDR),
  .KEY_C(KEY_C)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .prot_unlocked(prot_unlocked), .viol_flag(viol_flag),
  .clk_src_sel(clk_src_sel), .wdt_clk_en(wdt_clk_en), .bod_thresh(bod_thresh),
  .bod_en(bod_en), .lvr_en(lvr_en)
);

// File: tb/wp_unlock_ctrl_tb.sv
module wp_unlock_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        prot_unlocked, viol_flag, wdt_clk_en, bod_en, lvr_en;
  logic [1:0]  clk_src_sel;
  logic [2:0]  bod_thresh;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wp_unlock_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .prot_unlocked(prot_unlocked), .viol_flag(viol_flag),
    .clk_src_sel(clk_src_sel), .wdt_clk_en(wdt_clk_en),
    .bod_thresh(bod_thresh), .bod_en(bod_en), .lvr_en(lvr_en)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_key();
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
  endtask

  task automatic relock();
    if (prot_unlocked) wr(4'h0, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 unlocked", {15'b0, prot_unlocked}, 16'h0);
    check("R1 viol", {15'b0, viol_flag}, 16'h0);
    rd(4'h0, d); check("R1 lock reg", d, 16'h0000);
    rd(4'h2, d); check("R1 clk reg", d, 16'h0000);
    rd(4'h3, d); check("R1 pwr reg", d, 16'h0080);
  endtask

  task automatic t_unlock();
    logic [15:0] d;
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0016);
    check("R2 not open after two words", {15'b0, prot_unlocked}, 16'h0);
    wr(4'h0, 16'h0088);
    check("R2 open after key", {15'b0, prot_unlocked}, 16'h1);
    rd(4'h0, d); check("R2 lock reg bit0", d, 16'h0001);
    relock();
    wr(4'h0, 16'h0159); wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R2 upper bits must match", {15'b0, prot_unlocked}, 16'h0);
  endtask

  task automatic t_wrong_word();
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0017); wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R3 wrong word aborts", {15'b0, prot_unlocked}, 16'h0);
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0016); wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R3 wrong third word aborts", {15'b0, prot_unlocked}, 16'h0);
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0059); wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R3 repeated first word restarts", {15'b0, prot_unlocked}, 16'h1);
    relock();
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0016); wr(4'h0, 16'h0059);
    wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R3 first word in third slot restarts", {15'b0, prot_unlocked}, 16'h1);
    relock();
  endtask

  task automatic t_foreign_write();
    wr(4'h0, 16'h0059); wr(4'h4, 16'h1234); wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R4 foreign write after first word", {15'b0, prot_unlocked}, 16'h0);
    wr(4'h0, 16'h0059); wr(4'h0, 16'h0016); wr(4'h9, 16'h0000); wr(4'h0, 16'h0088);
    check("R4 foreign write before last word", {15'b0, prot_unlocked}, 16'h0);
  endtask

  task automatic t_reads();
    logic [15:0] d;
    wr(4'h0, 16'h0059); rd(4'h0, d); rd(4'h3, d);
    wr(4'h0, 16'h0016); rd(4'h7, d);
    wr(4'h0, 16'h0088);
    check("R5 reads do not break key", {15'b0, prot_unlocked}, 16'h1);
    rd(4'h0, d); rd(4'h2, d);
    check("R5 reads keep guard open", {15'b0, prot_unlocked}, 16'h1);
    relock();
  endtask

  task automatic t_relock();
    do_key();
    wr(4'h0, 16'h0059);
    check("R6 any write relocks", {15'b0, prot_unlocked}, 16'h0);
    wr(4'h0, 16'h0016); wr(4'h0, 16'h0088);
    check("R6 relock write is not a key word", {15'b0, prot_unlocked}, 16'h0);
  endtask

  task automatic t_guarded();
    logic [15:0] d;
    wr(4'h2, 16'h0013); wr(4'h3, 16'h000F);
    check("R7 clk sel held", {14'b0, clk_src_sel}, 16'h0);
    check("R7 wdt held", {15'b0, wdt_clk_en}, 16'h0);
    check("R7 thresh held", {13'b0, bod_thresh}, 16'h0);
    check("R7 lvr held", {15'b0, lvr_en}, 16'h1);
    do_key();
    wr(4'h2, 16'h0012); wr(4'h3, 16'h000B);
    check("R7 clk sel written", {14'b0, clk_src_sel}, 16'h2);
    check("R7 thresh written", {13'b0, bod_thresh}, 16'h5);
    check("R7 bod en written", {15'b0, bod_en}, 16'h1);
    check("R7 lvr written", {15'b0, lvr_en}, 16'h0);
    rd(4'h2, d); check("R7 clk reg readback", d, 16'h0012);
    relock();
    wr(4'h2, 16'h0001); wr(4'h3, 16'h0080);
    rd(4'h2, d); check("R7 clk reg after relock", d, 16'h0012);
    rd(4'h3, d); check("R7 pwr reg after relock", d, 16'h000B);
    wr(4'h1, 16'h0001);
  endtask

  task automatic t_scratch();
    logic [15:0] d;
    wr(4'h4, 16'hA5C3); rd(4'h4, d); check("R8 scratch while closed", d, 16'hA5C3);
    do_key();
    wr(4'h4, 16'h0F0F); rd(4'h4, d); check("R8 scratch while open", d, 16'h0F0F);
    relock();
  endtask

  task automatic t_viol();
    logic [15:0] d;
    check("R9 flag clear at start", {15'b0, viol_flag}, 16'h0);
    wr(4'h3, 16'h0000);
    check("R9 flag set", {15'b0, viol_flag}, 16'h1);
    wr(4'h1, 16'h0000);
    check("R9 write 0 keeps flag", {15'b0, viol_flag}, 16'h1);
    rd(4'h1, d); check("R9 status readback", d, 16'h0001);
    wr(4'h1, 16'h0001);
    check("R9 write 1 clears", {15'b0, viol_flag}, 16'h0);
    do_key(); wr(4'h2, 16'h0000);
    check("R9 no flag while open", {15'b0, viol_flag}, 16'h0);
    relock();
  endtask

  task automatic t_readport();
    logic [15:0] d;
    wr(4'h4, 16'h5555);
    rd(4'hE, d); check("R10 unmapped reads 0", d, 16'h0000);
    @(negedge clk); bus_addr = 4'h4; bus_rd = 1'b1;
    #1 check("R10 rdata not yet updated", bus_rdata, 16'h0000);
    @(negedge clk); bus_rd = 1'b0;
    check("R10 rdata one cycle later", bus_rdata, 16'h5555);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unlock();
    t_wrong_word();
    t_foreign_write();
    t_reads();
    t_relock();
    t_guarded();
    t_scratch();
    t_viol();
    t_readport();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule